// File: doc/BRIEF.md
# Time-Shared Half-Width Unsigned Multiplier

This block forms the full double-width product of two unsigned operands while owning only one multiplier of half the operand width. Each operand is cut into a low and a high half. The four half-by-half products are made one per clock and added, each at its own bit offset, into a product-wide accumulator. A plain ripple adder does the addition, so the design gives up throughput to save area.

A client presents both operands and raises `start` for one cycle while the block is idle. The block captures the operands and clears its accumulator. It then spends four cycles on the partial products and raises `done` for one cycle when `product` holds the result. The result stays on `product` until the next accepted start. With the default parameter the operands are 32 bits and the product is 64 bits.

Top module: `mulseq_top`

## Requirements
- R1: While reset is held, and after it is released, `busy` and `done` are 0 and `product` is 0.
- R2: When `done` is 1, `product` equals the unsigned product of the `op_a` and `op_b` values that were present at the clock edge where `start` was accepted.
- R3: A start is accepted at a rising clock edge where `start` is 1 and `busy` is 0. `busy` is 1 for exactly the four cycles after that edge. `done` is 1 in the cycle after them, which is the fifth cycle after the accepting edge.
- R4: `done` stays high for a single cycle only.
- R5: While the block is idle and `start` is 0, `product` keeps its value.
- R6: A `start` raised while `busy` is 1 has no effect, and changes on `op_a` or `op_b` after the accepting edge do not alter the result.
- R7: Every accepted start clears the accumulator, so a result holds nothing of the product before it.
- R8: The low-by-low product is placed at bit 0, both cross products at bit HALF_W, and the high-by-high product at bit 2*HALF_W. An operand that has only its high half set therefore yields a product shifted by HALF_W.
- R9: A start may be accepted in the same cycle that `done` is high, which gives one result every five cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a product; taken only when idle |
| op_a | input | 2*HALF_W | Multiplicand, unsigned |
| op_b | input | 2*HALF_W | Multiplier, unsigned |
| busy | output | 1 | High while partial products are being accumulated |
| done | output | 1 | One-cycle pulse marking a valid product |
| product | output | 4*HALF_W | Unsigned product; held until the next accepted start |

## Verification
The bench builds two copies of the block. The first has HALF_W = 3, so the operands are 6 bits wide. This makes it practical to sweep every one of the 4096 operand pairs, so every carry between partial products and every half placement is checked against plain arithmetic. The sweep mixes isolated and back-to-back requests, and it raises stray starts and changes the operands during busy cycles. The second copy has the default HALF_W = 16. It takes directed corner cases: all-ones operands, operands with only one half set, and powers of two that cross the half boundary.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mulseq_state_e;

    // number of half-by-half partial products and the index of the last one
    localparam int unsigned NUM_PARTIALS = 4;
    localparam logic [1:0]  LAST_STEP    = 2'(NUM_PARTIALS - 1);

endpackage

// File: rtl/mulseq_select.sv
// Picks the operand halves and the placement code for one partial product.
// step[0] selects the high half of A, step[1] the high half of B.
module mulseq_select #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned OP_W  = 2 * HALF_W
) (
    input  logic [1:0]        step,
    input  logic [OP_W-1:0]   opa,
    input  logic [OP_W-1:0]   opb,
    output logic [HALF_W-1:0] half_a,
    output logic [HALF_W-1:0] half_b,
    output logic [1:0]        place
);

    always_comb begin
        half_a = step[0] ? opa[OP_W-1:HALF_W] : opa[HALF_W-1:0];
        half_b = step[1] ? opb[OP_W-1:HALF_W] : opb[HALF_W-1:0];
        // place counts how many high halves take part: 0, 1 or 2
        place  = {1'b0, step[0]} + {1'b0, step[1]};
    end

endmodule

// File: rtl/mulseq_mul.sv
// The single shared half-width multiplier, followed by positioning.
module mulseq_mul #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned PP_W  = 2 * HALF_W,
    localparam int unsigned PROD_W = 4 * HALF_W
) (
    input  logic [HALF_W-1:0] half_a,
    input  logic [HALF_W-1:0] half_b,
    input  logic [1:0]        place,
    output logic [PROD_W-1:0] pp_pos
);

    logic [PP_W-1:0]   pp;
    logic [PROD_W-1:0] pp_ext;

    always_comb begin
        pp     = PP_W'(half_a) * PP_W'(half_b);
        pp_ext = PROD_W'(pp);
        unique case (place)
            2'd0:    pp_pos = pp_ext;
            2'd1:    pp_pos = pp_ext << HALF_W;
            default: pp_pos = pp_ext << PP_W;
        endcase
    end

endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
    import mulseq_pkg::*;
#(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned OP_W   = 2 * HALF_W,
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              busy,
    output logic              done,
    output logic [PROD_W-1:0] product
);

    typedef struct packed {
        mulseq_state_e     st;
        logic [1:0]        step;
        logic [OP_W-1:0]   a;
        logic [OP_W-1:0]   b;
        logic [PROD_W-1:0] acc;
        logic              done;
    } mulseq_regs_t;

    mulseq_regs_t r_q, r_d;

    logic [HALF_W-1:0] half_a, half_b;
    logic [1:0]        place;
    logic [PROD_W-1:0] pp_pos;

    mulseq_select #(.HALF_W(HALF_W)) u_select (
        .step   (r_q.step),
        .opa    (r_q.a),
        .opb    (r_q.b),
        .half_a (half_a),
        .half_b (half_b),
        .place  (place)
    );

    mulseq_mul #(.HALF_W(HALF_W)) u_mul (
        .half_a (half_a),
        .half_b (half_b),
        .place  (place),
        .pp_pos (pp_pos)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.a    = op_a;
                    r_d.b    = op_b;
                    r_d.acc  = '0;
                    r_d.step = '0;
                    r_d.st   = ST_RUN;
                end
            end
            ST_RUN: begin
                // ripple accumulate of the positioned partial product
                r_d.acc  = r_q.acc + pp_pos;
                r_d.step = r_q.step + 2'd1;
                if (r_q.step == LAST_STEP) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, step: '0, a: '0, b: '0, acc: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.st == ST_RUN);
    assign done    = r_q.done;
    assign product = r_q.acc;

endmodule

// File: rtl/mulseq_chk.sv
module mulseq_chk #(
    parameter int unsigned HALF_W = 16,
    localparam int unsigned OP_W   = 2 * HALF_W,
    localparam int unsigned PROD_W = 2 * OP_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic              busy,
    input logic              done,
    input logic [PROD_W-1:0] product
);

    logic [OP_W-1:0]   ref_a, ref_b;
    logic [PROD_W-1:0] ref_p;
    logic [2:0]        busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_a    <= '0;
            ref_b    <= '0;
            busy_cnt <= '0;
        end else begin
            if (start && !busy) begin
                ref_a <= op_a;
                ref_b <= op_b;
            end
            busy_cnt <= busy ? busy_cnt + 3'd1 : 3'd0;
        end
    end

    assign ref_p = PROD_W'(ref_a) * PROD_W'(ref_b);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (!busy && !done && product == '0); // R1
        end
    end

    AST_PRODUCT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == ref_p); // R2

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_cnt < 3'd4); // R3

    AST_DONE_AFTER_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_cnt == 3'd4 && !busy); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product)); // R5

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R6

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> product == '0); // R7

endmodule

bind mulseq_top mulseq_chk #(.HALF_W(HALF_W)) u_mulseq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/tb_mulseq_top.sv
`timescale 1ns/1ps
module tb_mulseq_top;

    localparam int unsigned SH = 3;          // small copy: 6-bit operands
    localparam int unsigned SO = 2 * SH;
    localparam int unsigned SP = 2 * SO;
    localparam int unsigned FH = 16;         // default copy: 32-bit operands
    localparam int unsigned FO = 2 * FH;
    localparam int unsigned FP = 2 * FO;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          s_start = 1'b0;
    logic [SO-1:0] s_a = '0, s_b = '0;
    logic          s_busy, s_done;
    logic [SP-1:0] s_prod;

    logic          f_start = 1'b0;
    logic [FO-1:0] f_a = '0, f_b = '0;
    logic          f_busy, f_done;
    logic [FP-1:0] f_prod;

    mulseq_top #(.HALF_W(SH)) dut (
        .clk(clk), .rst_n(rst_n), .start(s_start), .op_a(s_a), .op_b(s_b),
        .busy(s_busy), .done(s_done), .product(s_prod)
    );

    mulseq_top #(.HALF_W(FH)) dut_full (
        .clk(clk), .rst_n(rst_n), .start(f_start), .op_a(f_a), .op_b(f_b),
        .busy(f_busy), .done(f_done), .product(f_prod)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One request on the small copy; called at a falling edge.
    task automatic run_s(input int a, input int b, input bit poke, input bit settle);
        logic [63:0] exp;
        exp = 64'(a) * 64'(b);
        s_a = SO'(a); s_b = SO'(b); s_start = 1'b1;
        @(negedge clk);
        chk(s_busy && !s_done, "R3 busy after accept", 64'(s_busy), 64'd1);
        s_a = ~SO'(a); s_b = SO'(b) ^ SO'(5);
        s_start = poke;                       // R6 stray start while busy
        @(negedge clk);
        s_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(s_busy && !s_done, "R3 still busy at fourth cycle", 64'(s_done), 64'd0);
        @(negedge clk);
        chk(s_done && !s_busy, "R3 done in fifth cycle", 64'(s_done), 64'd1);
        chk(64'(s_prod) == exp, "R2 R6 R7 product", 64'(s_prod), exp);
        if (settle) begin
            @(negedge clk);
            chk(!s_done, "R4 done single cycle", 64'(s_done), 64'd0);
            chk(64'(s_prod) == exp, "R5 product held", 64'(s_prod), exp);
        end
    endtask

    task automatic run_f(input logic [FO-1:0] a, input logic [FO-1:0] b,
                         input string req);
        logic [63:0] exp;
        exp = 64'(a) * 64'(b);
        f_a = a; f_b = b; f_start = 1'b1;
        @(negedge clk);
        f_start = 1'b0; f_a = '1; f_b = '1;
        repeat (4) @(negedge clk);
        chk(f_done, {req, " done"}, 64'(f_done), 64'd1);
        chk(f_prod == exp, req, f_prod, exp);
        @(negedge clk);
        chk(!f_done && f_prod == exp, "R5 R4 full hold", f_prod, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!s_busy && !s_done && s_prod == '0, "R1 reset small", 64'(s_prod), 64'd0);
        chk(!f_busy && !f_done && f_prod == '0, "R1 reset full", f_prod, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!s_busy && !s_done && s_prod == '0, "R1 after release", 64'(s_prod), 64'd0);

        // exhaustive sweep; odd b runs back-to-back (R9)
        for (int a = 0; a < (1 << SO); a++) begin
            for (int b = 0; b < (1 << SO); b++) begin
                run_s(a, b, ((a + b) % 3) == 0, b[0] == 1'b0 || b == (1 << SO) - 1);
            end
        end

        // R8 placement corners on the default copy
        run_f(32'h0000_0000, 32'h0000_0000, "R2 zero");
        run_f(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 all ones");
        run_f(32'h0001_0000, 32'h0001_0000, "R8 high by high");
        run_f(32'hFFFF_0000, 32'h0000_FFFF, "R8 cross high-low");
        run_f(32'h0000_FFFF, 32'hFFFF_0000, "R8 cross low-high");
        run_f(32'h8000_0000, 32'h0000_0002, "R8 carry into upper word");
        run_f(32'h0000_0001, 32'hFFFF_FFFF, "R2 identity");
        run_f(32'h1234_5678, 32'h9ABC_DEF0, "R2 mixed");

        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule